// File: doc/BRIEF.md
# Vector Compare and Condition Evaluator

This block runs the compare step of a shader core. Each compare instruction provides two source vectors of single-precision lanes and one instruction word. The word holds two independent 3-bit relation codes. One code compares the x lanes of the two sources and the other compares the y lanes. The two results are written into two persistent condition flags, here called `flag_x` and `flag_y`. These flags keep their values until the next compare instruction runs.

The block also has a purely combinational branch port. A flow-control instruction supplies two reference bits and a 2-bit combine mode. The port tests each stored flag for equality with its reference bit. It then merges the two test results as an OR, an AND, the y test alone or the x test alone. The sequencer uses the result to decide whether a jump, call or conditional block is taken. Operand fetch and instruction sequencing sit outside the block.

Top module: `vcmp_cond_unit`

## Requirements
- R1: While `rst_n` is low, and directly after it is released, `flag_x` and `flag_y` are both 0.
- R2: When `cmp_valid` is low at a clock edge, neither flag changes, whatever is on the instruction and source inputs.
- R3: When `cmp_valid` is high at an edge, `flag_x` takes the result of the relation code in `cmp_instr[26:24]` applied to the x lanes, which are `src1_vec[31:0]` against `src2_vec[31:0]`. In the same edge, `flag_y` takes the result of the code in `cmp_instr[23:21]` applied to the y lanes, which are bits [63:32]. The new flags are visible from the following cycle. All other instruction bits and lanes are ignored.
- R4: Relation codes 0 to 5 test src1 against src2 as follows: 0 equal, 1 not equal, 2 less than, 3 less or equal, 4 greater than, 5 greater or equal.
- R5: Relation codes 6 and 7 give a true result for any operands, including NaN.
- R6: Lanes are ordered as IEEE-754 single-precision values. +0 and -0 compare equal, denormals are ordered by value, and the infinities are the extreme values.
- R7: If either lane is a NaN (exponent all ones, mantissa non-zero), codes 0, 2, 3, 4 and 5 give false and code 1 gives true.
- R8: `br_taken` is formed from tx = (`flag_x` == `br_ref_x`) and ty = (`flag_y` == `br_ref_y`). `br_mode` selects how they are merged: 0 gives tx OR ty, 1 gives tx AND ty, 2 gives ty, and 3 gives tx.
- R9: If a branch is evaluated in the same cycle as a compare is issued, `br_taken` uses the flags as they were before that compare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_valid | input | 1 | A compare instruction executes this cycle |
| cmp_instr | input | 32 | Compare instruction word; relation codes at [26:24] (x) and [23:21] (y) |
| src1_vec | input | 128 | First source vector, x lane [31:0], y lane [63:32] |
| src2_vec | input | 128 | Second source vector, same lane layout |
| br_mode | input | 2 | Branch combine mode |
| br_ref_x | input | 1 | Reference bit tested against flag_x |
| br_ref_y | input | 1 | Reference bit tested against flag_y |
| flag_x | output | 1 | Stored x condition flag |
| flag_y | output | 1 | Stored y condition flag |
| br_taken | output | 1 | Combinational branch condition |

## Verification
A compare update and a branch evaluation can happen in the same cycle. In that cycle the flags are being rewritten while the branch port is still reading them. The bench drives a valid compare and a branch request on the same edge, using operands chosen so that the new flags differ from the old ones. It then checks that `br_taken`, sampled before the edge, matches the model's old flags, and that the flags read after the edge show the new results. A reference model compares values converted to real numbers, with NaNs handled separately. The model runs on every cycle over a pool of signed zeros, denormals, infinities and NaNs, so that these cases collide often.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;

   typedef enum logic [2:0] {
      REL_EQ  = 3'd0,
      REL_NE  = 3'd1,
      REL_LT  = 3'd2,
      REL_LE  = 3'd3,
      REL_GT  = 3'd4,
      REL_GE  = 3'd5,
      REL_T6  = 3'd6,
      REL_T7  = 3'd7
   } rel_code_e;

   typedef enum logic [1:0] {
      MRG_OR  = 2'd0,
      MRG_AND = 2'd1,
      MRG_Y   = 2'd2,
      MRG_X   = 2'd3
   } merge_mode_e;

   typedef struct packed {
      logic eq;
      logic lt;
      logic gt;
      logic unord;
   } rel_flags_t;

   // Turns the raw ordering flags into the result of one relation code.
   function automatic logic rel_apply(rel_code_e code, rel_flags_t f);
      logic r;
      case (code)
         REL_EQ:  r = f.eq;
         REL_NE:  r = ~f.eq | f.unord;
         REL_LT:  r = f.lt;
         REL_LE:  r = f.lt | f.eq;
         REL_GT:  r = f.gt;
         REL_GE:  r = f.gt | f.eq;
         default: r = 1'b1;
      endcase
      if (f.unord && code != REL_NE && code != REL_T6 && code != REL_T7)
         r = 1'b0;
      return r;
   endfunction

endpackage

// File: rtl/vcmp_lane_order.sv
module vcmp_lane_order
   import vcmp_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter bit NAN_AWARE = 1'b1,
   localparam int LANE_W   = 1 + EXP_W + MAN_W
) (
   input  logic [LANE_W-1:0] lane_a,
   input  logic [LANE_W-1:0] lane_b,
   output rel_flags_t        order
);

   localparam int MAG_W = EXP_W + MAN_W;

   logic             sign_a, sign_b;
   logic [MAG_W-1:0] mag_a, mag_b;
   logic             zero_pair;
   logic             unord;

   assign sign_a    = lane_a[LANE_W-1];
   assign sign_b    = lane_b[LANE_W-1];
   assign mag_a     = lane_a[MAG_W-1:0];
   assign mag_b     = lane_b[MAG_W-1:0];
   assign zero_pair = ~|mag_a & ~|mag_b;

   generate
      if (NAN_AWARE) begin : g_nan_detect
         logic nan_a, nan_b;
         assign nan_a = (&mag_a[MAG_W-1:MAN_W]) & (|mag_a[MAN_W-1:0]);
         assign nan_b = (&mag_b[MAG_W-1:MAN_W]) & (|mag_b[MAN_W-1:0]);
         assign unord = nan_a | nan_b;
      end else begin : g_nan_blind
         assign unord = 1'b0;
      end
   endgenerate

   logic eq_raw, lt_raw;

   always_comb begin
      eq_raw = zero_pair | (lane_a == lane_b);
      if (zero_pair) begin
         lt_raw = 1'b0;
      end else begin
         case ({sign_a, sign_b})
            2'b10:   lt_raw = 1'b1;
            2'b01:   lt_raw = 1'b0;
            2'b00:   lt_raw = mag_a < mag_b;
            default: lt_raw = mag_a > mag_b;
         endcase
      end
   end

   assign order.eq    = eq_raw & ~unord;
   assign order.lt    = lt_raw & ~unord;
   assign order.gt    = ~eq_raw & ~lt_raw & ~unord;
   assign order.unord = unord;

endmodule

// File: rtl/vcmp_flag_store.sv
module vcmp_flag_store #(
   parameter int NUM_FLAGS = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 load,
   input  logic [NUM_FLAGS-1:0] next_flags,
   output logic [NUM_FLAGS-1:0] flags
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         flags <= '0;
      else if (load)
         flags <= next_flags;
   end

endmodule

// File: rtl/vcmp_branch_eval.sv
module vcmp_branch_eval
   import vcmp_pkg::*;
(
   input  logic        flag_x,
   input  logic        flag_y,
   input  logic        ref_x,
   input  logic        ref_y,
   input  merge_mode_e mode,
   output logic        taken
);

   logic hit_x, hit_y;

   assign hit_x = ~(flag_x ^ ref_x);
   assign hit_y = ~(flag_y ^ ref_y);

   always_comb begin
      case (mode)
         MRG_OR:  taken = hit_x | hit_y;
         MRG_AND: taken = hit_x & hit_y;
         MRG_Y:   taken = hit_y;
         default: taken = hit_x;
      endcase
   end

endmodule

// File: rtl/vcmp_cond_unit.sv
module vcmp_cond_unit
   import vcmp_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int MAN_W     = 23,
   parameter int NUM_LANES = 4,
   parameter int INSTR_W   = 32,
   parameter int X_LANE    = 0,
   parameter int Y_LANE    = 1,
   parameter int XOP_LSB   = 24,
   parameter int YOP_LSB   = 21,
   parameter bit NAN_AWARE = 1'b1,
   localparam int LANE_W   = 1 + EXP_W + MAN_W,
   localparam int VEC_W    = NUM_LANES * LANE_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmp_valid,
   input  logic [INSTR_W-1:0] cmp_instr,
   input  logic [VEC_W-1:0]   src1_vec,
   input  logic [VEC_W-1:0]   src2_vec,
   input  logic [1:0]         br_mode,
   input  logic               br_ref_x,
   input  logic               br_ref_y,
   output logic               flag_x,
   output logic               flag_y,
   output logic               br_taken
);

   localparam int OP_W     = 3;
   localparam int NUM_CH   = 2;

   // Elaboration-time parameter checks
   generate
      if (X_LANE >= NUM_LANES || Y_LANE >= NUM_LANES) begin : g_bad_lane
         $error("vcmp_cond_unit: lane index outside the vector");
      end
      if (XOP_LSB + OP_W > INSTR_W || YOP_LSB + OP_W > INSTR_W) begin : g_bad_field
         $error("vcmp_cond_unit: relation field outside the instruction word");
      end
      if (EXP_W < 2 || MAN_W < 1) begin : g_bad_fmt
         $error("vcmp_cond_unit: float format too narrow");
      end
   endgenerate

   // Channel 0 = x, channel 1 = y
   localparam int CH_LANE [NUM_CH] = '{X_LANE, Y_LANE};
   localparam int CH_OP   [NUM_CH] = '{XOP_LSB, YOP_LSB};

   logic [NUM_CH-1:0] ch_result;
   logic [NUM_CH-1:0] stored;

   genvar ch;
   generate
      for (ch = 0; ch < NUM_CH; ch++) begin : g_chan
         rel_flags_t  order;
         rel_code_e   code;

         assign code = rel_code_e'(cmp_instr[CH_OP[ch] +: OP_W]);

         vcmp_lane_order #(
            .EXP_W     (EXP_W),
            .MAN_W     (MAN_W),
            .NAN_AWARE (NAN_AWARE)
         ) u_order (
            .lane_a (src1_vec[CH_LANE[ch]*LANE_W +: LANE_W]),
            .lane_b (src2_vec[CH_LANE[ch]*LANE_W +: LANE_W]),
            .order  (order)
         );

         assign ch_result[ch] = rel_apply(code, order);
      end
   endgenerate

   vcmp_flag_store #(
      .NUM_FLAGS (NUM_CH)
   ) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (cmp_valid),
      .next_flags (ch_result),
      .flags      (stored)
   );

   assign flag_x = stored[0];
   assign flag_y = stored[1];

   vcmp_branch_eval u_branch (
      .flag_x (stored[0]),
      .flag_y (stored[1]),
      .ref_x  (br_ref_x),
      .ref_y  (br_ref_y),
      .mode   (merge_mode_e'(br_mode)),
      .taken  (br_taken)
   );

endmodule

// File: rtl/vcmp_cond_checker.sv
module vcmp_cond_checker #(
   parameter int LANE_W  = 32,
   parameter int MAN_W   = 23,
   parameter int VEC_W   = 128,
   parameter int INSTR_W = 32,
   parameter int XOP_LSB = 24,
   parameter int YOP_LSB = 21
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmp_valid,
   input logic [INSTR_W-1:0] cmp_instr,
   input logic [VEC_W-1:0]   src1_vec,
   input logic [VEC_W-1:0]   src2_vec,
   input logic [1:0]         br_mode,
   input logic               br_ref_x,
   input logic               br_ref_y,
   input logic               flag_x,
   input logic               flag_y,
   input logic               br_taken
);

   logic [2:0] op_x, op_y;
   logic       nan_x;
   logic [LANE_W-2:0] m1, m2;

   assign op_x  = cmp_instr[XOP_LSB +: 3];
   assign op_y  = cmp_instr[YOP_LSB +: 3];
   assign m1    = src1_vec[LANE_W-2:0];
   assign m2    = src2_vec[LANE_W-2:0];
   assign nan_x = ((&m1[LANE_W-2:MAN_W]) & (|m1[MAN_W-1:0])) |
                  ((&m2[LANE_W-2:MAN_W]) & (|m2[MAN_W-1:0]));

   a_r1_reset_clear: assert property (@(posedge clk)
      !rst_n |-> (!flag_x && !flag_y));

   a_r2_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !cmp_valid |=> ($stable(flag_x) && $stable(flag_y)));

   a_r5_forced_true: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && op_x[2:1] == 2'b11 && op_y[2:1] == 2'b11) |=> (flag_x && flag_y));

   a_r7_nan_unordered: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && nan_x && op_x != 3'd1 && op_x[2:1] != 2'b11) |=> !flag_x);

   a_r6_same_bits_equal: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_valid && !nan_x && op_x == 3'd0 &&
       src1_vec[LANE_W-1:0] == src2_vec[LANE_W-1:0]) |=> flag_x);

   a_r8_and_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
      (br_mode == 2'd1 && br_taken) |-> (flag_x == br_ref_x && flag_y == br_ref_y));

   a_r9_x_only_old_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (br_mode == 2'd3) |-> (br_taken == (flag_x == br_ref_x)));

endmodule

bind vcmp_cond_unit vcmp_cond_checker #(
   .LANE_W  (LANE_W),
   .MAN_W   (MAN_W),
   .VEC_W   (VEC_W),
   .INSTR_W (INSTR_W),
   .XOP_LSB (XOP_LSB),
   .YOP_LSB (YOP_LSB)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmp_valid (cmp_valid),
   .cmp_instr (cmp_instr),
   .src1_vec  (src1_vec),
   .src2_vec  (src2_vec),
   .br_mode   (br_mode),
   .br_ref_x  (br_ref_x),
   .br_ref_y  (br_ref_y),
   .flag_x    (flag_x),
   .flag_y    (flag_y),
   .br_taken  (br_taken)
);

// File: tb/sim_vcmp_cond_unit.sv
module sim_vcmp_cond_unit;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cmp_valid = 1'b0;
   logic [31:0]  cmp_instr = '0;
   logic [127:0] src1_vec = '0;
   logic [127:0] src2_vec = '0;
   logic [1:0]   br_mode = '0;
   logic         br_ref_x = 1'b0;
   logic         br_ref_y = 1'b0;
   logic         flag_x, flag_y, br_taken;

   int  n_vec = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   bit  mdl_x = 1'b0;
   bit  mdl_y = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   vcmp_cond_unit u0 (
      .clk (clk), .rst_n (rst_n), .cmp_valid (cmp_valid), .cmp_instr (cmp_instr),
      .src1_vec (src1_vec), .src2_vec (src2_vec), .br_mode (br_mode),
      .br_ref_x (br_ref_x), .br_ref_y (br_ref_y),
      .flag_x (flag_x), .flag_y (flag_y), .br_taken (br_taken)
   );

   localparam logic [31:0] POOL [13] = '{
      32'h0000_0000, 32'h8000_0000, 32'h3F80_0000, 32'hBF80_0000,
      32'h4000_0000, 32'h0000_0001, 32'h8000_0001, 32'h7F80_0000,
      32'hFF80_0000, 32'h7FC0_0000, 32'hFFC0_0001, 32'h3F80_0001,
      32'h7F7F_FFFF };

   function automatic bit is_nan(logic [31:0] v);
      return (v[30:23] == 8'hFF) && (v[22:0] != 0);
   endfunction

   function automatic real to_real(logic [31:0] v);
      real mag;
      int  e;
      e = int'(v[30:23]);
      if (e == 255)      mag = 1.0e300;
      else if (e == 0)   mag = real'(v[22:0]) * (2.0 ** -149);
      else               mag = (1.0 + real'(v[22:0]) / 8388608.0) * (2.0 ** (e - 127));
      return v[31] ? -mag : mag;
   endfunction

   function automatic bit ref_rel(int code, logic [31:0] a, logic [31:0] b);
      real ra, rb;
      if (code >= 6) return 1'b1;
      if (is_nan(a) || is_nan(b)) return code == 1;
      ra = to_real(a);
      rb = to_real(b);
      case (code)
         0: return ra == rb;
         1: return ra != rb;
         2: return ra <  rb;
         3: return ra <= rb;
         4: return ra >  rb;
         default: return ra >= rb;
      endcase
   endfunction

   function automatic bit ref_branch(int mode, bit fx, bit fy, bit rx, bit ry);
      bit tx, ty;
      tx = (fx == rx);
      ty = (fy == ry);
      case (mode)
         0: return tx || ty;
         1: return tx && ty;
         2: return ty;
         default: return tx;
      endcase
   endfunction

   task automatic check(string req, logic act, logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: got %b expected %b", req, $time, act, exp);
      end
   endtask

   // One cycle: drive at the falling edge, check the branch output before the
   // rising edge against the old flags, then check the flags after the edge.
   task automatic step(bit v, int opx, int opy, logic [31:0] ax, logic [31:0] bx,
                       logic [31:0] ay, logic [31:0] by, int mode, bit rx, bit ry,
                       string req);
      bit nx, ny;
      logic [31:0] word;
      word        = $urandom;
      word[26:24] = 3'(opx);
      word[23:21] = 3'(opy);
      cmp_valid   = v;
      cmp_instr   = word;
      src1_vec    = {$urandom, $urandom, ay, ax};
      src2_vec    = {$urandom, $urandom, by, bx};
      br_mode     = 2'(mode);
      br_ref_x    = rx;
      br_ref_y    = ry;
      nx = ref_rel(opx, ax, bx);
      ny = ref_rel(opy, ay, by);
      #2;
      check({req, " R8 R9 branch"}, br_taken, ref_branch(mode, mdl_x, mdl_y, rx, ry));
      @(posedge clk);
      if (v) begin
         mdl_x = nx;
         mdl_y = ny;
      end
      @(negedge clk);
      check({req, " flag_x"}, flag_x, mdl_x);
      check({req, " flag_y"}, flag_y, mdl_y);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      @(negedge clk);
      cmp_valid = 1'b1;
      cmp_instr = 32'h0700_0000 | (32'h7 << 21);
      repeat (3) @(negedge clk);
      check("R1 reset flag_x", flag_x, 1'b0);
      check("R1 reset flag_y", flag_y, 1'b0);
      cmp_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release flag_x", flag_x, 1'b0);
      check("R1 after release flag_y", flag_y, 1'b0);

      // R5: forced-true codes, even with NaN
      step(1, 6, 7, 32'h7FC0_0000, 32'h0, 32'h3F80_0000, 32'h7FC0_0000, 0, 0, 0, "R5");
      // R2: idle cycles keep flags while inputs would clear them
      step(0, 0, 0, 32'h3F80_0000, 32'h4000_0000, 32'h0, 32'h3F80_0000, 1, 1, 1, "R2 idle");
      step(0, 2, 4, 32'h4000_0000, 32'h3F80_0000, 32'h0, 32'h0, 3, 0, 1, "R2 idle");
      // R9: compare and branch in the same cycle, flags flip
      step(1, 0, 1, 32'h3F80_0000, 32'h4000_0000, 32'h0, 32'h0, 1, 1, 1, "R9 overlap");
      step(0, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0, 1, 0, 0, "R9 follow");
      // R6: signed zeros and infinities
      step(1, 0, 3, 32'h0000_0000, 32'h8000_0000, 32'hFF80_0000, 32'h7F7F_FFFF, 2, 0, 1, "R6 zeros inf");
      step(1, 2, 4, 32'h8000_0001, 32'h0000_0000, 32'h7F80_0000, 32'h7F7F_FFFF, 0, 1, 0, "R6 denorm");
      // R7: NaN behaviour per code
      for (int c = 0; c < 6; c++)
         step(1, c, c, 32'hFFC0_0001, 32'h3F80_0000, 32'h0, 32'h7FC0_0000, c % 4, c[0], c[1], "R7 nan");
      // R4/R3: each code on ordered lanes, x and y with different codes
      for (int c = 0; c < 6; c++) begin
         step(1, c, 5 - c, 32'hBF80_0000, 32'h3F80_0000, 32'h4000_0000, 32'h4000_0000, 3, 1, 0, "R4 R3 codes");
         step(1, c, 5 - c, 32'h3F80_0001, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0001, 2, 1, 1, "R4 R3 codes");
      end
      // R8: all modes against all reference pairs
      for (int m = 0; m < 4; m++)
         for (int r = 0; r < 4; r++)
            step(r == 0, m % 6, (m + 3) % 6, 32'h4000_0000, 32'h3F80_0000, 32'h0, 32'h3F80_0000,
                 m, r[0], r[1], "R8 modes");

      // Random mix from the interesting pool and random bit patterns
      for (int i = 0; i < 3000; i++) begin
         logic [31:0] v [4];
         for (int k = 0; k < 4; k++)
            v[k] = ($urandom_range(3) == 0) ? 32'($urandom) : POOL[$urandom_range(12)];
         if ($urandom_range(1)) v[1] = v[0];
         step($urandom_range(3) != 0, $urandom_range(7), $urandom_range(7),
              v[0], v[1], v[2], v[3], $urandom_range(3), 1'($urandom), 1'($urandom),
              "R3 R4 R6 R7 R8 random");
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule